// File: doc/BRIEF.md
# Sequential Hysteresis Space-Vector Selector

This block turns four hysteresis comparator bits into three inverter leg commands. Each leg command is one bit, so the three bits pick one of eight voltage vectors. The comparators place the two-axis current error against two nested squares on axes a and b. The block picks a vector that drives the error back toward the inner tolerance square.

A plain lookup table would leave three comparator codes open:
- two half-strip codes, each of which allows two neighbouring active vectors;
- the tolerance code, which allows either of the two zero vectors.

To settle these, the block keeps two pieces of history:
- the command it applied last;
- the side of the b axis on which the error was last seen outside the band.

Zero vectors are chosen so that at most one leg switches. Half-strip choices pick the vector that pushes the b component back from the side it most recently left.

State and output change only on clock edges where the sampling strobe is high. A designer can therefore set the strobe period longer than the ringing that sensor noise causes after each switching event.

Top module: `hvs_selector`

## Requirements
- R1: While rst_ni is low, and after it is released, leg_o is 000. The remembered b side starts as low.
- R2: On a clock edge where sample_i is low, leg_o and all history hold, whatever cmp_i does.
- R3: Comparator bit layout:
  - Axis a uses cmp_i[3] (upper) and cmp_i[1] (lower). Axis b uses cmp_i[2] (upper) and cmp_i[0] (lower).
  - For each axis, upper/lower = 1/1 means error high, 0/0 means error low, and 0/1 means inside.
- R4: The six active vectors form a ring ordered by angle: 100, 110, 010, 011, 001, 101. Neighbours in the ring differ in one leg.
- R5: Codes with one result:
  - 0111 gives 001; 0010 gives 110.
  - 0101 gives 101; 1111 gives 011; 0000 gives 100; 1010 gives 010.
  - Every code other than the tolerance code gives an active vector, never 000 or 111.
- R6: The tolerance code 0011 gives 000 if the previous command had at most one leg set, and 111 otherwise.
- R7: Half-strip codes use the remembered b side:
  - Code 0001 gives 101 when the remembered b side is high, and 100 when it is low.
  - Code 1011 gives 011 when the remembered b side is high, and 010 when it is low.
  - The remembered b side updates on every sampled code whose b axis is high or low. It holds when the b axis is inside.
- R8: A sampled tolerance code changes at most one leg of leg_o.
- R9: An axis whose upper/lower pair is 1/0 (a code that only appears after a comparator reset) is treated as inside. This covers both the vector choice and the b-side history.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| sample_i | input | 1 | Sampling strobe; state advances only when high |
| cmp_i | input | 4 | Comparator bits {a_up, b_up, a_lo, b_lo} |
| leg_o | output | 3 | Registered leg switch commands |

## Verification
The hardest case to reach is a half-strip code whose answer depends on history. That history may be several samples old and may have been left unchanged by codes in between that had an inside b axis. To reach it, the stimulus walks the error from each quarter-plane into the adjacent half-strip. It then returns to the same half-strip after passing through the tolerance code and through the b-inside codes that only occur after a comparator reset. Long random runs with a gated strobe then mix these histories with held cycles. Every clock, the output is compared with a behavioural model.

// File: rtl/hvs_pkg.sv
package hvs_pkg;
  localparam int CMP_W    = 4;
  localparam int LEG_W    = 3;
  localparam int NUM_SECT = 6;
  localparam int NUM_AX   = CMP_W / 2;

  typedef logic [LEG_W-1:0] leg_t;
  typedef enum logic [1:0] {AX_LOW = 2'd0, AX_IN = 2'd1, AX_HIGH = 2'd2} axis_e;

  // ring of active vectors, ascending angle; neighbours differ in one leg
  localparam leg_t SECT_CMD [NUM_SECT] = '{3'b100, 3'b110, 3'b010, 3'b011, 3'b001, 3'b101};
  localparam leg_t ZERO_LO = '0;
  localparam leg_t ZERO_HI = '1;

  function automatic int unsigned leg_ones(leg_t v);
    int unsigned n;
    n = 0;
    for (int i = 0; i < LEG_W; i++) n += int'(v[i]);
    return n;
  endfunction
endpackage

// File: rtl/hvs_axis_decode.sv
module hvs_axis_decode
  import hvs_pkg::*;
(
  input  logic  hi_i,
  input  logic  lo_i,
  output axis_e ax_o
);
  always_comb begin
    unique case ({hi_i, lo_i})
      2'b11:   ax_o = AX_HIGH;
      2'b00:   ax_o = AX_LOW;
      default: ax_o = AX_IN;  // 10 only after comparator reset: treat as inside (R9)
    endcase
  end
endmodule

// File: rtl/hvs_vector_pick.sv
module hvs_vector_pick
  import hvs_pkg::*;
(
  input  axis_e ax_a_i,
  input  axis_e ax_b_i,
  input  leg_t  last_cmd_i,
  input  logic  b_side_hi_i,
  output leg_t  nxt_cmd_o
);
  leg_t zero_cmd;

  // zero vector nearest to the last command: at most one leg moves
  assign zero_cmd = (leg_ones(last_cmd_i) >= 2) ? ZERO_HI : ZERO_LO;

  always_comb begin
    nxt_cmd_o = zero_cmd;
    unique case (ax_a_i)
      AX_LOW: begin
        unique case (ax_b_i)
          AX_HIGH: nxt_cmd_o = SECT_CMD[5];
          AX_LOW:  nxt_cmd_o = SECT_CMD[0];
          default: nxt_cmd_o = b_side_hi_i ? SECT_CMD[5] : SECT_CMD[0];
        endcase
      end
      AX_HIGH: begin
        unique case (ax_b_i)
          AX_HIGH: nxt_cmd_o = SECT_CMD[3];
          AX_LOW:  nxt_cmd_o = SECT_CMD[2];
          default: nxt_cmd_o = b_side_hi_i ? SECT_CMD[3] : SECT_CMD[2];
        endcase
      end
      default: begin
        unique case (ax_b_i)
          AX_HIGH: nxt_cmd_o = SECT_CMD[4];
          AX_LOW:  nxt_cmd_o = SECT_CMD[1];
          default: nxt_cmd_o = zero_cmd;
        endcase
      end
    endcase
  end
endmodule

// File: rtl/hvs_state.sv
module hvs_state
  import hvs_pkg::*;
(
  input  logic  clk_i,
  input  logic  rst_ni,
  input  logic  en_i,
  input  leg_t  nxt_cmd_i,
  input  axis_e ax_b_i,
  output leg_t  cmd_o,
  output logic  b_side_hi_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cmd_o       <= ZERO_LO;
      b_side_hi_o <= 1'b0;
    end else if (en_i) begin
      cmd_o <= nxt_cmd_i;
      if (ax_b_i == AX_HIGH)     b_side_hi_o <= 1'b1;
      else if (ax_b_i == AX_LOW) b_side_hi_o <= 1'b0;
    end
  end

  AST_HOLD_NO_STROBE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !en_i |=> ($stable(cmd_o) && $stable(b_side_hi_o))); // R2
endmodule

// File: rtl/hvs_selector.sv
module hvs_selector
  import hvs_pkg::*;
(
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             sample_i,
  input  logic [CMP_W-1:0] cmp_i,
  output logic [LEG_W-1:0] leg_o
);
  axis_e ax [NUM_AX];
  leg_t  nxt_cmd;
  leg_t  cmd_q;
  logic  b_side_hi;

  // axis g: upper bit at CMP_W-1-g, lower bit at NUM_AX-1-g
  for (genvar g = 0; g < NUM_AX; g++) begin : g_ax
    hvs_axis_decode u_dec (
      .hi_i (cmp_i[CMP_W-1-g]),
      .lo_i (cmp_i[NUM_AX-1-g]),
      .ax_o (ax[g])
    );
  end

  hvs_vector_pick u_pick (
    .ax_a_i      (ax[0]),
    .ax_b_i      (ax[1]),
    .last_cmd_i  (cmd_q),
    .b_side_hi_i (b_side_hi),
    .nxt_cmd_o   (nxt_cmd)
  );

  hvs_state u_state (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .en_i        (sample_i),
    .nxt_cmd_i   (nxt_cmd),
    .ax_b_i      (ax[1]),
    .cmd_o       (cmd_q),
    .b_side_hi_o (b_side_hi)
  );

  assign leg_o = cmd_q;

  AST_ZERO_ONE_LEG: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (sample_i && cmp_i == 4'b0011) |=>
      ((leg_o == ZERO_LO || leg_o == ZERO_HI) && $countones(leg_o ^ $past(leg_o)) <= 1)); // R8

  AST_ACTIVE_OUTSIDE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (sample_i && !(ax[0] == AX_IN && ax[1] == AX_IN)) |=>
      (leg_o != ZERO_LO && leg_o != ZERO_HI)); // R5

  AST_B_STRIP_HIGH: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (sample_i && cmp_i == 4'b0111) |=> (leg_o == 3'b001)); // R5

  AST_HALF_STRIP_KEEP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (sample_i && cmp_i == 4'b0101) ##1 (sample_i && cmp_i == 4'b0001) |=> $stable(leg_o)); // R7
endmodule

// File: tb/hvs_selector_bench.sv
`timescale 1ns/1ps
module hvs_selector_bench;
  localparam real HALF = 2.0;  // 250 MHz

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       sample = 1'b0;
  logic [3:0] cmp = 4'b0011;
  logic [2:0] leg;

  int checks = 0;
  int fails  = 0;
  bit done   = 0;

  // model state
  logic [2:0] m_cmd = 3'b000;
  bit         m_bhi = 0;
  string      m_tag = "R1";

  always #(HALF) clk = ~clk;

  hvs_selector u_hvs_selector (
    .clk_i(clk), .rst_ni(rst_n), .sample_i(sample), .cmp_i(cmp), .leg_o(leg)
  );

  // R3: per-axis decode, +1 high, -1 low, 0 inside (R9: 10 counts as inside)
  function automatic int ax_of(logic up, logic lo);
    if (up && lo) return 1;
    if (!up && !lo) return -1;
    return 0;
  endfunction

  // R4 ring, index by angle step
  function automatic logic [2:0] ring(int i);
    case (i)
      0: return 3'b100; 1: return 3'b110; 2: return 3'b010;
      3: return 3'b011; 4: return 3'b001; default: return 3'b101;
    endcase
  endfunction

  function automatic int ones3(logic [2:0] v);
    return int'(v[0]) + int'(v[1]) + int'(v[2]);
  endfunction

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_cmd = 3'b000; m_bhi = 0; m_tag = "R1";
    end else if (sample) begin
      int a, b;
      logic [2:0] prev;
      prev = m_cmd;
      a = ax_of(cmp[3], cmp[1]);
      b = ax_of(cmp[2], cmp[0]);
      m_tag = "R3 R5";
      if (a == 0 && b == 0) begin
        m_cmd = (ones3(prev) >= 2) ? 3'b111 : 3'b000;
        m_tag = "R6";
        checks++;
        if (ones3(m_cmd ^ prev) > 1) begin
          fails++;
          $display("FAIL R8 model zero step flips %0d legs, expected <=1", ones3(m_cmd ^ prev));
        end
      end else if (b == 0) begin
        if (a < 0) m_cmd = m_bhi ? ring(5) : ring(0);
        else       m_cmd = m_bhi ? ring(3) : ring(2);
        m_tag = "R4 R7";
      end else if (a == 0) m_cmd = (b > 0) ? ring(4) : ring(1);
      else if (a < 0)      m_cmd = (b > 0) ? ring(5) : ring(0);
      else                 m_cmd = (b > 0) ? ring(3) : ring(2);
      if ((cmp[3] && !cmp[1]) || (cmp[2] && !cmp[0])) m_tag = {m_tag, " R9"};
      if (b > 0) m_bhi = 1;
      else if (b < 0) m_bhi = 0;
    end else begin
      m_tag = "R2";
    end
  end

  logic [2:0] last_leg = 3'b000;
  always @(negedge clk) begin
    if (!done) begin
      checks++;
      if (leg !== m_cmd) begin
        fails++;
        $display("FAIL %s leg_o=%b expected %b", m_tag, leg, m_cmd);
      end
      if (m_tag == "R6") begin  // R8 at the port
        checks++;
        if (ones3(leg ^ last_leg) > 1) begin
          fails++;
          $display("FAIL R8 flips=%0d expected <=1", ones3(leg ^ last_leg));
        end
      end
      last_leg = leg;
    end
  end

  task automatic step(logic [3:0] c, logic s);
    @(negedge clk);
    #0.5;
    cmp = c; sample = s;
  endtask

  task automatic finish_run();
    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  endtask

  initial begin
    #(HALF * 2 * 200000);
    fails++;
    $display("FAIL watchdog expired, expected completion");
    finish_run();
  end

  initial begin
    repeat (3) @(negedge clk);  // R1 reset state checked each cycle
    #0.5 rst_n = 1'b1;
    step(4'b0011, 1); step(4'b0000, 1); step(4'b0011, 1);   // R6 from 100 -> 000
    step(4'b1111, 1); step(4'b0011, 1);                     // R6 from 011 -> 111
    step(4'b0111, 1); step(4'b0011, 1); step(4'b0010, 1);   // R5
    step(4'b0101, 1); step(4'b0001, 1);                     // R7 b high -> 101
    step(4'b0000, 1); step(4'b0001, 1);                     // R7 b low -> 100
    step(4'b1111, 1); step(4'b0011, 1); step(4'b1011, 1);   // R7 history over TR -> 011
    step(4'b1010, 1); step(4'b1011, 1);                     // R7 -> 010
    step(4'b0111, 1); step(4'b0100, 1); step(4'b0001, 1);   // R9 b inside keeps high side
    step(4'b1000, 1); step(4'b1110, 1); step(4'b1001, 1);   // R9 codes
    step(4'b0000, 0); step(4'b1111, 0); step(4'b0011, 0);   // R2 hold
    for (int i = 0; i < 4000; i++) begin
      logic [3:0] c;
      c = 4'($urandom_range(0, 15));
      step(c, 1'($urandom_range(0, 2) != 0));
    end
    step(4'b0000, 1); step(4'b0000, 1);
    #0.5 rst_n = 1'b0;                                      // R1 async reset
    repeat (2) @(negedge clk);
    #0.5 rst_n = 1'b1;
    step(4'b0011, 1); step(4'b0011, 1);
    @(negedge clk);
    @(negedge clk);
    finish_run();
  end
endmodule